// File: doc/BRIEF.md
# Polling Bus Arbiter

This block arbitrates a shared bus among a parameterised number of masters without sending a grant line to each one. Instead it broadcasts a device number, the poll count, together with a strobe that says whether the number may be acted on. While at least one master is requesting, the count walks upward through the device numbers and wraps back to zero. A requesting master that sees its own number with the strobe high claims the bus. It does this by raising its busy line in the following cycle and holding it for the length of its transfer.

The arbiter treats busy as a level. While any busy bit is high the count is frozen and the strobe is low. When busy falls, the count moves on to the next device number, so the search always continues past the last owner and service rotates. Priority among masters that request at the same time follows the order in which the count visits them, starting from where it currently stands. The arbiter also reports which device holds the bus, taken from the busy bits.

Top module: `poll_bus_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the poll count to 0. While reset is applied and the inputs are idle, and in the first cycle after reset with no request, the strobe and the owner-valid output are both 0.
- R2: With no request bit set, no busy bit set and no release pending, the poll count keeps its value and the strobe is 0.
- R3: While requests are pending and the bus is idle, the count advances by one each cycle past non-requesting device numbers. It wraps from NUM_DEV-1 to 0, and the strobe is 1.
- R4: When the count reaches a number whose request bit is set, the count stops there and the strobe stays 1 until that device takes the bus or withdraws its request.
- R5: While any busy bit is 1, the poll count does not change and the strobe is 0.
- R6: The owner-valid output is 1 exactly when some busy bit is 1, and the owner number then equals the index of that busy bit. When no busy bit is set, the owner number is 0.
- R7: In the cycle after busy falls, the strobe is 0 and the count then moves to the next device number (modulo NUM_DEV), whether or not the previous owner still requests.
- R8: A device that withdraws its request before the count reaches it is passed over with no stall.
- R9: Among masters requesting at the same time, the first one the count reaches, counting upward from its current value, is the first that can take the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_DEV | Request bit per master |
| busy | input | NUM_DEV | Busy bit per master, high while it owns the bus |
| poll_cnt | output | $clog2(NUM_DEV) | Broadcast device number |
| poll_vld | output | 1 | The poll count may be matched by a requester |
| owner_vld | output | 1 | Some master holds the bus |
| owner_id | output | $clog2(NUM_DEV) | Number of the master holding the bus |

## Verification
The strobe and the owner outputs depend on the inputs of the current cycle and on the state of the previous cycle, so they are due in the same cycle as the stimulus. The poll count is registered and reflects an input change one rising edge later. The driver applies each cycle's request and busy pattern just after a falling edge and queues the values expected for that cycle. Those expected values already include the effect of every earlier edge. The monitor compares the outputs shortly after the same falling edge, well clear of the next rising edge, so the combinational outputs have settled and the count has not yet moved.

// File: rtl/poll_bus_arbiter.sv
module poll_bus_arbiter #(
  parameter int NUM_DEV = 6,
  localparam int CW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] req,
  input  logic [NUM_DEV-1:0] busy,
  output logic [CW-1:0]      poll_cnt,
  output logic               poll_vld,
  output logic               owner_vld,
  output logic [CW-1:0]      owner_id
);

  localparam logic [CW-1:0] LAST = CW'(NUM_DEV - 1);

  logic [CW-1:0] cnt;
  logic          busy_q;
  logic          any_req, any_busy, hit;
  logic [CW-1:0] cnt_inc;

  assign any_req  = |req;
  assign any_busy = |busy;
  assign hit      = req[cnt];
  assign cnt_inc  = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= any_busy;
      if (any_busy)
        cnt <= cnt;
      else if (busy_q)
        cnt <= cnt_inc;
      else if (any_req && !hit)
        cnt <= cnt_inc;
    end
  end

  assign poll_cnt  = cnt;
  assign poll_vld  = any_req && !any_busy && !busy_q;
  assign owner_vld = any_busy;

  always_comb begin
    owner_id = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (busy[i]) owner_id = CW'(i);
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> poll_cnt == '0);

  // R5
  frozen_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    owner_vld |=> $stable(poll_cnt));

  // R5
  no_strobe_while_owned_chk: assert property (@(posedge clk) disable iff (rst)
    poll_vld |-> !owner_vld);

  // R6
  owner_matches_poll_chk: assert property (@(posedge clk) disable iff (rst)
    owner_vld |-> owner_id == poll_cnt);

  // R6
  single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busy));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_req && !any_busy && !busy_q) |=> $stable(poll_cnt));

endmodule

// File: tb/poll_bus_arbiter_tb.sv
module poll_bus_arbiter_tb;
  localparam int N  = 6;
  localparam int CW = $clog2(N);

  typedef struct {
    logic [CW-1:0] cnt;
    logic          vld;
    logic          own;
    logic [CW-1:0] id;
    string         tag;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic [N-1:0] req  = '0;
  logic [N-1:0] busy = '0;
  logic [CW-1:0] poll_cnt, owner_id;
  logic poll_vld, owner_vld;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  poll_bus_arbiter #(.NUM_DEV(N)) u_dut (
    .clk(clk), .rst(rst), .req(req), .busy(busy),
    .poll_cnt(poll_cnt), .poll_vld(poll_vld),
    .owner_vld(owner_vld), .owner_id(owner_id)
  );

  task automatic step(input logic r, input logic [N-1:0] rq, input logic [N-1:0] bz,
                      input int c, input logic v, input logic o, input int id, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; req = rq; busy = bz;
    e.cnt = CW'(c); e.vld = v; e.own = o; e.id = CW'(id); e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (poll_cnt !== e.cnt || poll_vld !== e.vld || owner_vld !== e.own || owner_id !== e.id) begin
          n_fail++;
          $display("FAIL %s: got cnt=%0d vld=%0b own=%0b id=%0d, want cnt=%0d vld=%0b own=%0b id=%0d",
                   e.tag, poll_cnt, poll_vld, owner_vld, owner_id, e.cnt, e.vld, e.own, e.id);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got no end, want end of run");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    step(0, 6'b000000, 6'b000000, 0, 0, 0, 0, "R1");
    step(0, 6'b000000, 6'b000000, 0, 0, 0, 0, "R2");
    step(0, 6'b000100, 6'b000000, 0, 1, 0, 0, "R3");
    step(0, 6'b000100, 6'b000000, 1, 1, 0, 0, "R3");
    step(0, 6'b000100, 6'b000000, 2, 1, 0, 0, "R4");
    step(0, 6'b000100, 6'b000100, 2, 0, 1, 2, "R6");
    step(0, 6'b000000, 6'b000100, 2, 0, 1, 2, "R5");
    step(0, 6'b000000, 6'b000000, 2, 0, 0, 0, "R7");
    step(0, 6'b000000, 6'b000000, 3, 0, 0, 0, "R7");
    step(0, 6'b010010, 6'b000000, 3, 1, 0, 0, "R9");
    step(0, 6'b010010, 6'b000000, 4, 1, 0, 0, "R9");
    step(0, 6'b010010, 6'b010000, 4, 0, 1, 4, "R9");
    step(0, 6'b000010, 6'b000000, 4, 0, 0, 0, "R7");
    step(0, 6'b000010, 6'b000000, 5, 1, 0, 0, "R3");
    step(0, 6'b000010, 6'b000000, 0, 1, 0, 0, "R3");
    step(0, 6'b000010, 6'b000000, 1, 1, 0, 0, "R4");
    step(0, 6'b000010, 6'b000010, 1, 0, 1, 1, "R6");
    step(0, 6'b000000, 6'b000000, 1, 0, 0, 0, "R7");
    step(0, 6'b110000, 6'b000000, 2, 1, 0, 0, "R8");
    step(0, 6'b100000, 6'b000000, 3, 1, 0, 0, "R8");
    step(0, 6'b100000, 6'b000000, 4, 1, 0, 0, "R8");
    step(0, 6'b100000, 6'b000000, 5, 1, 0, 0, "R4");
    step(0, 6'b100000, 6'b100000, 5, 0, 1, 5, "R6");
    step(0, 6'b000000, 6'b000000, 5, 0, 0, 0, "R7");
    step(0, 6'b000000, 6'b000000, 0, 0, 0, 0, "R7");
    step(0, 6'b000000, 6'b000000, 0, 0, 0, 0, "R2");
    step(0, 6'b000100, 6'b000000, 0, 1, 0, 0, "R3");
    step(1, 6'b000000, 6'b000000, 1, 0, 0, 0, "R1");
    step(0, 6'b000000, 6'b000000, 0, 0, 0, 0, "R1");
    @(negedge clk);
    #4;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule